// File: doc/BRIEF.md
# Staggered I/Q Burst Merger

This block gathers the outputs of several parallel decimating channels onto one output word. The channels run in a fixed stagger, so their output windows come one after another. When a channel has a result, it raises an active-high valid strobe for exactly two clocks. It presents the in-phase word on the first of those clocks and the quadrature word on the second. The merger watches all strobes together. It forwards whichever channel is currently strobing into a single registered output word. The output therefore cycles through the channels in the order their windows arrive.

Each forwarded word appears one clock after its input clock. A fresh-word flag marks that clock, and a quadrature flag tells the two halves of a burst apart. Between bursts there are idle gaps, about ten clocks with four channels at a twelve-clock slot. During a gap the output word keeps the last quadrature value until the next strobe. Two kinds of misuse are caught and recorded in one sticky error flag:
- strobes from two channels on the same clock;
- a strobe held longer than two clocks.

Top module: `iq_burst_merger`

## Requirements
- R1: A synchronous active-high reset clears `out_word` to 0 and clears `out_fresh`, `out_is_q` and `err_sticky`. It also clears all burst tracking, so the next strobe clock counts as the first word of a burst.
- R2: On a clock where exactly one channel k has its `ch_valid` bit set, the next clock shows `out_fresh` = 1 and `out_word` equal to the word channel k presented. Channel k's word occupies bits [k*DATA_W +: DATA_W] of `ch_data`.
- R3: `out_is_q` is 0 on the fresh word from the first strobe clock of a burst and 1 on the fresh word from the second. It is 0 whenever `out_fresh` is 0.
- R4: On a clock where no `ch_valid` bit is set, the next clock shows `out_fresh` = 0 and `out_word` unchanged. After a burst, the last Q word therefore stays on the output through the idle gap.
- R5: Bursts from channels 0, 1, 2 and 3 arriving in turn are forwarded in that order, as I/Q pairs, with no error raised.
- R6: When several `ch_valid` bits are set on one clock, only the lowest-numbered channel's word is forwarded. The other channels' words on that clock are discarded.
- R7: Two or more `ch_valid` bits set on the same clock set `err_sticky` on the next clock.
- R8: A channel strobe held for more than two consecutive clocks sets `err_sticky`. Only the first two words of that burst are forwarded, as I then Q. The later words are not loaded, and `out_fresh` stays 0 for them.
- R9: Once set, `err_sticky` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_valid | input | NUM_CH | Per-channel output strobe, active high, two clocks per burst |
| ch_data | input | NUM_CH*DATA_W | Per-channel words, channel k in bits [k*DATA_W +: DATA_W] |
| out_word | output | DATA_W | Registered merged output word, held between bursts |
| out_fresh | output | 1 | High on the clock after a word is loaded |
| out_is_q | output | 1 | 0 for an I word, 1 for a Q word |
| err_sticky | output | 1 | Collision or over-long burst seen since reset |

## Verification
Two functions can land on the same clock: forwarding a word and recording a collision. This happens when two channels strobe together. The bench provokes it by starting two-clock bursts on channels 1 and 2 at the same instant. The scoreboard expects only channel 1's I and Q words, and the error flag is judged on the clocks that follow. Over-long strobes are judged the same way: the scoreboard holds no entry for the third word, so any extra load shows up as an unexpected output.

// File: rtl/iqm_pkg.sv
package iqm_pkg;
  // Position of the current strobe clock within a channel's burst
  typedef enum logic [1:0] {
    RUN_I    = 2'd0,
    RUN_Q    = 2'd1,
    RUN_OVER = 2'd2
  } run_t;
endpackage

// File: rtl/iqm_run_tracker.sv
module iqm_run_tracker
  import iqm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  output run_t run
);
  run_t run_q;

  // Counts consecutive strobe clocks and saturates at RUN_OVER
  always_ff @(posedge clk) begin
    if (rst || !valid) run_q <= RUN_I;
    else if (run_q == RUN_I) run_q <= RUN_Q;
    else run_q <= RUN_OVER;
  end

  assign run = run_q;

  // R1: after a clock without a strobe, the next strobe starts a new burst
  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    !valid |=> run == RUN_I);
endmodule

// File: rtl/iqm_lowest_pick.sv
module iqm_lowest_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Scan from the top down, so the lowest requesting index is written last
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end

  // R6: the chosen channel is requesting, and no lower channel is
  always_comb begin
    if (any) begin
      a_pick_r6: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/iq_burst_merger.sv
module iq_burst_merger
  import iqm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        ch_valid,
  input  logic [NUM_CH*DATA_W-1:0] ch_data,
  output logic [DATA_W-1:0]        out_word,
  output logic                     out_fresh,
  output logic                     out_is_q,
  output logic                     err_sticky
);
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  run_t              runs [NUM_CH];
  logic [NUM_CH-1:0] over;
  logic [IW-1:0]     sel_idx;
  logic              any_valid;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_trk
      iqm_run_tracker u_trk (
        .clk   (clk),
        .rst   (rst),
        .valid (ch_valid[g]),
        .run   (runs[g])
      );
      assign over[g] = ch_valid[g] && (runs[g] == RUN_OVER);
    end
  endgenerate

  iqm_lowest_pick #(.N(NUM_CH)) u_pick (
    .req (ch_valid),
    .idx (sel_idx),
    .any (any_valid)
  );

  run_t              sel_run;
  logic [DATA_W-1:0] sel_word;
  logic              load;
  logic              collide;

  always_comb begin
    sel_run  = runs[sel_idx];
    sel_word = ch_data[sel_idx*DATA_W +: DATA_W];
    load     = any_valid && (sel_run != RUN_OVER);
    collide  = (ch_valid & (ch_valid - NUM_CH'(1))) != '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word   <= '0;
      out_fresh  <= 1'b0;
      out_is_q   <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      out_fresh  <= load;
      out_is_q   <= load && (sel_run == RUN_Q);
      if (load) out_word <= sel_word;
      err_sticky <= err_sticky || collide || (|over);
    end
  end

  // R4: with no strobe anywhere, the output holds and no fresh word is flagged
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ch_valid == '0) |=> (!out_fresh && $stable(out_word)));

  // R3: the quadrature flag is only raised together with a fresh word
  p_q_fresh_r3: assert property (@(posedge clk) disable iff (rst)
    out_is_q |-> out_fresh);

  // R2 and R6: channel 0 always wins, so a fresh word after its strobe is its own
  p_ch0_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ch_valid[0] |=> (!out_fresh || out_word == $past(ch_data[DATA_W-1:0])));

  // R7: a collision raises the error flag
  p_collide_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(ch_valid) > 1) |=> err_sticky);

  // R8: a strobe clock past the second word raises the error flag
  p_long_r8: assert property (@(posedge clk) disable iff (rst)
    (|over) |=> err_sticky);

  // R9: the error flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
endmodule

// File: tb/sim_iq_burst_merger.sv
module sim_iq_burst_merger;
  localparam int NCH = 4;
  localparam int W   = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH-1:0]   vin = '0;
  logic [W-1:0]     din [NCH];
  logic [NCH*W-1:0] ch_data;
  logic [W-1:0]     out_word;
  logic             out_fresh, out_is_q, err_sticky;

  int checks = 0;
  int failures = 0;
  logic [W:0] exp_q [$];   // {is_q, word}
  bit done = 0;

  always #4 clk = ~clk;    // 125 MHz

  always_comb begin
    for (int k = 0; k < NCH; k++) ch_data[k*W +: W] = din[k];
  end

  iq_burst_merger #(.NUM_CH(NCH), .DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .ch_valid(vin), .ch_data(ch_data),
    .out_word(out_word), .out_fresh(out_fresh), .out_is_q(out_is_q),
    .err_sticky(err_sticky)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: checks each fresh word against the scoreboard just after the edge
  always @(posedge clk) begin
    #1;
    if (!rst && out_fresh) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 R8 unexpected word", {15'd0, out_is_q, out_word}, 32'hFFFFFFFF);
      end else begin
        logic [W:0] e;
        e = exp_q.pop_front();
        chk({out_is_q, out_word} == e, "R2 R3 R5 R6 word/flag",
            {15'd0, out_is_q, out_word}, {15'd0, e});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int ch, input logic [W-1:0] iw, input logic [W-1:0] qw);
    @(negedge clk);
    vin[ch] = 1'b1; din[ch] = iw; exp_q.push_back({1'b0, iw});
    @(negedge clk);
    din[ch] = qw; exp_q.push_back({1'b1, qw});
    @(negedge clk);
    vin[ch] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; vin = '0;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) din[k] = '0;
    idle(3);
    rst = 1'b0;
    // R1: reset state
    chk(out_word == '0, "R1 out_word", 32'(out_word), 0);
    chk(!out_fresh && !out_is_q, "R1 flags", {30'd0, out_fresh, out_is_q}, 0);
    chk(!err_sticky, "R1 err_sticky", 32'(err_sticky), 0);

    // R5: staggered round robin, R4 hold through the idle gaps
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [W-1:0] iw, qw;
        iw = W'(16'h1000 + r*16'h100 + c*16'h10);
        qw = W'(16'h2000 + r*16'h100 + c*16'h10 + 1);
        burst(c, iw, qw);
        idle(10);
        chk(out_word == qw && !out_fresh, "R4 hold last Q",
            {15'd0, out_fresh, out_word}, {16'd0, qw});
      end
    end
    chk(exp_q.size() == 0, "R5 all words forwarded", exp_q.size(), 0);
    chk(!err_sticky, "R5 no error in normal flow", 32'(err_sticky), 0);

    // R6/R7: channels 1 and 2 strobe together; channel 1 wins
    @(negedge clk);
    vin[1] = 1'b1; vin[2] = 1'b1; din[1] = 16'hA1A1; din[2] = 16'hB2B2;
    exp_q.push_back({1'b0, 16'hA1A1});
    @(negedge clk);
    din[1] = 16'hC3C3; din[2] = 16'hD4D4;
    exp_q.push_back({1'b1, 16'hC3C3});
    @(negedge clk);
    vin = '0;
    idle(3);
    chk(err_sticky, "R7 collision sets error", 32'(err_sticky), 1);
    chk(out_word == 16'hC3C3, "R6 lowest channel kept", 32'(out_word), 32'hC3C3);
    idle(10);
    chk(err_sticky, "R9 error stays set", 32'(err_sticky), 1);
    chk(exp_q.size() == 0, "R6 collision words", exp_q.size(), 0);

    do_reset();
    chk(!err_sticky && out_word == '0 && !out_fresh, "R1 reset clears",
        {15'd0, err_sticky, out_word}, 0);

    // R8: channel 3 holds its strobe for three clocks
    @(negedge clk);
    vin[3] = 1'b1; din[3] = 16'h0E0E; exp_q.push_back({1'b0, 16'h0E0E});
    @(negedge clk);
    din[3] = 16'h0F0F; exp_q.push_back({1'b1, 16'h0F0F});
    @(negedge clk);
    din[3] = 16'h0A0A;
    @(negedge clk);
    vin = '0;
    chk(!out_fresh && out_word == 16'h0F0F, "R8 third word not loaded",
        {15'd0, out_fresh, out_word}, 32'h0F0F);
    idle(2);
    chk(err_sticky, "R8 long burst sets error", 32'(err_sticky), 1);
    chk(exp_q.size() == 0, "R8 first two words forwarded", exp_q.size(), 0);

    // R3/R5: a normal burst after the error still pairs as I then Q
    burst(0, 16'h5555, 16'h6666);
    idle(4);
    chk(exp_q.size() == 0 && out_word == 16'h6666, "R3 burst after error",
        32'(out_word), 32'h6666);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule